// File: doc/BRIEF.md
# Vertical-Blanking Side-Channel Scheduler

This block carries auxiliary bytes in both directions over a video link without displacing any active pixel. It runs on the pixel clock and watches the vertical and horizontal sync inputs. Once a frame begins, it opens a transmit window on the first blanking line and a receive window on the second. The receive window opens only after a short turnaround guard, so the far end has time to take over the line. Each burst carries a length, one status byte from the sending end and up to a per-frame budget of payload bytes.

On the local side, bytes are written into a transmit buffer, and the block drains that buffer into the next forward burst. Bytes from a correct reverse burst are appended to a receive buffer that the local logic reads. The status byte of that burst is mirrored into a remote-status output. A burst that fails its check, is cut off by the window end, or declares an impossible length is dropped as a whole and counted. A disable input shuts both windows.

Top module: `sc_vblank_link`

## Requirements
- R1: `link_tx_en` is high only on the first line after a vertical sync rising edge. That line starts at the next `hsync` rising edge. The forward burst starts on that line with no idle symbols in between, and `link_tx_en` stays low on every other line.
- R2: Link symbols are 9 bits wide, and bit 8 marks a control code. A burst is sent in this order: control 0xFB, length L, status byte, L payload bytes, check byte, control 0xFD. The check byte is the XOR of the length, the status byte and every payload byte.
- R3: A burst carries at most 224 payload bytes. Any bytes beyond that stay in the transmit buffer, in order, for the next frame.
- R4: Received symbols are accepted only on the second blanking line, and only when the pixel index from that line's start is 16 or more. A start code that arrives earlier on that line has no effect.
- R5: After a correct reverse burst, its payload is readable from the receive buffer in arrival order, and `remote_status` takes the burst's status byte.
- R6: If the check byte of a reverse burst is wrong, none of its payload becomes readable, `remote_status` keeps its value, and `rx_err_cnt` rises by exactly 1.
- R7: A reverse burst is discarded and counted in `rx_err_cnt` in three cases: it is cut off by the end of the window, its length is above 224, or its length exceeds the free space in the receive buffer.
- R8: While `sc_disable` is high, no burst is sent or accepted, and the bytes waiting in the transmit buffer are kept.
- R9: A write while `tx_full` is high is refused, the buffer contents are unchanged, and the sticky `tx_overflow` output goes high.
- R10: After reset, `link_tx_en`, `tx_full`, `tx_overflow`, `remote_status` and `rx_err_cnt` are 0, and `rx_empty` is 1.
- R11: A forward burst is sent every enabled frame, even when the transmit buffer is empty (L = 0). It carries the `local_status` value sampled when the burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_disable | input | 1 | Closes both windows |
| vsync | input | 1 | Vertical sync, active high |
| hsync | input | 1 | Horizontal sync, active high |
| tx_wr_en | input | 1 | Write strobe for the transmit buffer |
| tx_wr_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit buffer full |
| tx_overflow | output | 1 | Sticky flag: a write was refused |
| local_status | input | 8 | Status byte sent in each forward burst |
| link_tx_en | output | 1 | Drive request for the link |
| link_tx_sym | output | 9 | Outgoing symbol, bit 8 marks a control code |
| link_rx_valid | input | 1 | Incoming symbol is valid |
| link_rx_sym | input | 9 | Incoming symbol, bit 8 marks a control code |
| rx_rd_en | input | 1 | Pop strobe for the receive buffer |
| rx_rd_data | output | 8 | Head of the receive buffer |
| rx_empty | output | 1 | Receive buffer holds no committed byte |
| remote_status | output | 8 | Status byte from the last correct reverse burst |
| rx_err_cnt | output | ERR_W | Saturating count of discarded bursts |

## Verification
The bench aims at five boundaries. The first is a transmit buffer holding more than 224 bytes: a design without the cap sends too many bytes, and one that mishandles the remainder sends the wrong bytes next frame. The second is a start code at pixel 15 versus pixel 16 of the reverse line. An off-by-one guard either swallows a legal burst or accepts one inside the turnaround. The third covers bursts that fail their check, are cut off by the line end, or declare 230 bytes. A design without the speculative write pointer leaves their bytes readable, or updates the remote status. The last two are a refused write into a full buffer, which a wrong design lets overwrite queued bytes, and a disabled frame, which a wrong design still drives or drains.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [7:0] K_START = 8'hFB;
    localparam logic [7:0] K_END   = 8'hFD;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } sym_t;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_ARMED,
        PH_FWD,
        PH_REV
    } phase_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LEN,
        TX_STAT,
        TX_PAY,
        TX_CHK,
        TX_END,
        TX_DONE
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_LEN,
        RX_STAT,
        RX_PAY,
        RX_CHK,
        RX_END
    } rx_state_t;

    function automatic sym_t make_sym(input logic ctrl, input logic [7:0] data);
        sym_t s;
        s.ctrl = ctrl;
        s.data = data;
        return s;
    endfunction

    function automatic logic is_code(input sym_t s, input logic [7:0] code);
        return s.ctrl && (s.data == code);
    endfunction

endpackage

// File: rtl/sc_line_timer.sv
module sc_line_timer
    import sc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sc_disable,
    input  logic             vsync,
    input  logic             hsync,
    output logic             win_fwd,
    output logic             win_rev,
    output logic [PIX_W-1:0] pix
);

    phase_t phase_q;
    logic   vs_q, hs_q;
    logic   vs_rise, hs_rise;

    assign vs_rise = vsync && !vs_q;
    assign hs_rise = hsync && !hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q    <= 1'b0;
            hs_q    <= 1'b0;
            phase_q <= PH_OFF;
            pix     <= '0;
        end else begin
            vs_q <= vsync;
            hs_q <= hsync;
            if (hs_rise)
                pix <= '0;
            else if (pix != '1)
                pix <= pix + 1'b1;

            if (sc_disable)
                phase_q <= PH_OFF;
            else if (vs_rise)
                phase_q <= PH_ARMED;
            else if (hs_rise) begin
                unique case (phase_q)
                    PH_ARMED: phase_q <= PH_FWD;
                    PH_FWD:   phase_q <= PH_REV;
                    default:  phase_q <= PH_OFF;
                endcase
            end
        end
    end

    assign win_fwd = (phase_q == PH_FWD);
    assign win_rev = (phase_q == PH_REV);

    // R1: the reverse line can only follow the forward line
    assert_line_order_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(win_rev) |-> $past(win_fwd));

endmodule

// File: rtl/sc_byte_fifo.sv
module sc_byte_fifo #(
    parameter int DEPTH = 256,
    parameter bit SPEC  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [7:0]                 din,
    input  logic                       pop,
    output logic [7:0]                 dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic [$clog2(DEPTH):0]     free,
    output logic                       full,
    input  logic                       commit,
    input  logic                       rollback
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]  mem [DEPTH];
    logic [AW:0] wr_spec, wr_cmt, rd;
    logic [AW:0] used;
    logic        do_push, do_pop;

    assign used    = wr_spec - rd;
    assign full    = (used == CW'(DEPTH));
    assign free    = CW'(DEPTH) - used;
    assign count   = wr_cmt - rd;
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rd[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_spec <= '0;
            rd      <= '0;
        end else begin
            if (SPEC && rollback)
                wr_spec <= wr_cmt;
            else if (do_push)
                wr_spec <= wr_spec + 1'b1;
            if (do_pop)
                rd <= rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_spec[AW-1:0]] <= din;
    end

    generate
        if (SPEC) begin : g_spec
            always_ff @(posedge clk) begin
                if (rst)
                    wr_cmt <= '0;
                else if (commit)
                    wr_cmt <= wr_spec;
            end
        end else begin : g_plain
            logic unused_commit;
            assign unused_commit = commit;
            assign wr_cmt = wr_spec;
        end
    endgenerate

    // R9: a push into a full buffer leaves the visible content untouched
    assert_refuse_full_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !commit) |=> (count == $past(count)));

endmodule

// File: rtl/sc_burst_tx.sv
module sc_burst_tx
    import sc_pkg::*;
#(
    parameter int MAX_BYTES = 224,
    parameter int CNT_W     = 9,
    parameter int PIX_W     = 12,
    parameter int START_PIX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win,
    input  logic [PIX_W-1:0] pix,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [7:0]       fifo_head,
    input  logic [7:0]       local_status,
    output logic             pop,
    output logic             en,
    output sym_t             sym
);

    tx_state_t  state;
    logic [7:0] len_q, left_q, stat_q, chk_q;
    logic [7:0] burst_len;
    logic [8:0] pay_cnt;
    logic       start;

    assign burst_len = (fifo_count > CNT_W'(MAX_BYTES)) ? 8'(MAX_BYTES) : fifo_count[7:0];
    assign start     = win && (state == TX_IDLE) && (pix == PIX_W'(START_PIX));
    assign pop       = win && (state == TX_PAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            en      <= 1'b0;
            sym     <= '0;
            len_q   <= '0;
            left_q  <= '0;
            stat_q  <= '0;
            chk_q   <= '0;
            pay_cnt <= '0;
        end else if (!win) begin
            state <= TX_IDLE;
            en    <= 1'b0;
        end else begin
            unique case (state)
                TX_IDLE: if (start) begin
                    sym     <= make_sym(1'b1, K_START);
                    en      <= 1'b1;
                    len_q   <= burst_len;
                    left_q  <= burst_len;
                    stat_q  <= local_status;
                    pay_cnt <= '0;
                    state   <= TX_LEN;
                end
                TX_LEN: begin
                    sym   <= make_sym(1'b0, len_q);
                    chk_q <= len_q;
                    state <= TX_STAT;
                end
                TX_STAT: begin
                    sym   <= make_sym(1'b0, stat_q);
                    chk_q <= chk_q ^ stat_q;
                    state <= (left_q == 8'd0) ? TX_CHK : TX_PAY;
                end
                TX_PAY: begin
                    sym     <= make_sym(1'b0, fifo_head);
                    chk_q   <= chk_q ^ fifo_head;
                    left_q  <= left_q - 8'd1;
                    pay_cnt <= pay_cnt + 9'd1;
                    if (left_q == 8'd1)
                        state <= TX_CHK;
                end
                TX_CHK: begin
                    sym   <= make_sym(1'b0, chk_q);
                    state <= TX_END;
                end
                TX_END: begin
                    sym   <= make_sym(1'b1, K_END);
                    state <= TX_DONE;
                end
                default: en <= 1'b0;
            endcase
        end
    end

    // R3: never pull from an empty buffer while sending payload
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fifo_count != '0));

    // R3: payload per burst stays within the budget
    assert_budget_R3: assert property (@(posedge clk) disable iff (rst)
        pay_cnt <= 9'(MAX_BYTES));

endmodule

// File: rtl/sc_burst_rx.sv
module sc_burst_rx
    import sc_pkg::*;
#(
    parameter int MAX_BYTES = 224,
    parameter int CNT_W     = 9,
    parameter int ERR_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win,
    input  logic             valid,
    input  sym_t             sym,
    input  logic [CNT_W-1:0] fifo_free,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic             rollback,
    output logic [7:0]       remote_status,
    output logic [ERR_W-1:0] err_cnt
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    rx_state_t  state;
    logic [7:0] left_q, stat_tmp, chk_q;
    logic       bad_q, chk_ok_q;
    logic       acc, abort_now;
    logic [ERR_W-1:0] err_next;

    assign acc      = win && valid;
    assign wr_en    = acc && (state == RX_PAY) && !sym.ctrl && !bad_q;
    assign wr_data  = sym.data;
    assign err_next = (err_cnt == ERR_MAX) ? err_cnt : err_cnt + 1'b1;

    always_comb begin
        abort_now = 1'b0;
        if (state != RX_IDLE && !win)
            abort_now = 1'b1;
        else if (acc && sym.ctrl && (state inside {RX_LEN, RX_STAT, RX_PAY, RX_CHK}))
            abort_now = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= RX_IDLE;
            left_q        <= '0;
            stat_tmp      <= '0;
            chk_q         <= '0;
            bad_q         <= 1'b0;
            chk_ok_q      <= 1'b0;
            commit        <= 1'b0;
            rollback      <= 1'b0;
            remote_status <= '0;
            err_cnt       <= '0;
        end else begin
            commit   <= 1'b0;
            rollback <= 1'b0;
            if (abort_now) begin
                state    <= RX_IDLE;
                rollback <= 1'b1;
                err_cnt  <= err_next;
            end else if (acc) begin
                unique case (state)
                    RX_IDLE: if (is_code(sym, K_START)) begin
                        bad_q <= 1'b0;
                        state <= RX_LEN;
                    end
                    RX_LEN: begin
                        left_q <= sym.data;
                        chk_q  <= sym.data;
                        bad_q  <= (sym.data > 8'(MAX_BYTES)) || (CNT_W'(sym.data) > fifo_free);
                        state  <= RX_STAT;
                    end
                    RX_STAT: begin
                        stat_tmp <= sym.data;
                        chk_q    <= chk_q ^ sym.data;
                        state    <= (left_q == 8'd0) ? RX_CHK : RX_PAY;
                    end
                    RX_PAY: begin
                        chk_q  <= chk_q ^ sym.data;
                        left_q <= left_q - 8'd1;
                        if (left_q == 8'd1)
                            state <= RX_CHK;
                    end
                    RX_CHK: begin
                        chk_ok_q <= (chk_q == sym.data);
                        state    <= RX_END;
                    end
                    default: begin
                        if (is_code(sym, K_END) && chk_ok_q && !bad_q) begin
                            commit        <= 1'b1;
                            remote_status <= stat_tmp;
                        end else begin
                            rollback <= 1'b1;
                            err_cnt  <= err_next;
                        end
                        state <= RX_IDLE;
                    end
                endcase
            end
        end
    end

    // R5: the mirrored status only moves together with a committed burst
    assert_status_commit_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(remote_status) |-> commit);

    // R6: the error counter moves by exactly one step
    assert_err_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_cnt) |-> (err_cnt == $past(err_cnt) + 1'b1));

    // R6: a burst is never committed and discarded at once
    assert_commit_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(commit && rollback));

endmodule

// File: rtl/sc_vblank_link.sv
module sc_vblank_link
    import sc_pkg::*;
#(
    parameter int TX_DEPTH  = 256,
    parameter int RX_DEPTH  = 256,
    parameter int MAX_BYTES = 224,
    parameter int GUARD     = 16,
    parameter int PIX_W     = 12,
    parameter int ERR_W     = 8,
    parameter bit FWD_SIDE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sc_disable,
    input  logic             vsync,
    input  logic             hsync,
    input  logic             tx_wr_en,
    input  logic [7:0]       tx_wr_data,
    output logic             tx_full,
    output logic             tx_overflow,
    input  logic [7:0]       local_status,
    output logic             link_tx_en,
    output logic [8:0]       link_tx_sym,
    input  logic             link_rx_valid,
    input  logic [8:0]       link_rx_sym,
    input  logic             rx_rd_en,
    output logic [7:0]       rx_rd_data,
    output logic             rx_empty,
    output logic [7:0]       remote_status,
    output logic [ERR_W-1:0] rx_err_cnt
);

    localparam int TX_CW    = $clog2(TX_DEPTH) + 1;
    localparam int RX_CW    = $clog2(RX_DEPTH) + 1;
    localparam int TX_START = FWD_SIDE ? 0 : GUARD;

    logic             win_fwd, win_rev;
    logic [PIX_W-1:0] pix;
    logic             tx_win, rx_win;
    logic             tx_pop;
    logic [7:0]       tx_head;
    logic [TX_CW-1:0] tx_count, tx_free_unused;
    logic [RX_CW-1:0] rx_count, rx_free;
    logic             rx_full_unused;
    logic             rx_push, rx_commit, rx_rollback;
    logic [7:0]       rx_push_data;
    sym_t             tx_sym;
    logic             ovf_q;

    sc_line_timer #(.PIX_W(PIX_W)) timer_i (
        .clk(clk), .rst(rst), .sc_disable(sc_disable),
        .vsync(vsync), .hsync(hsync),
        .win_fwd(win_fwd), .win_rev(win_rev), .pix(pix)
    );

    generate
        if (FWD_SIDE) begin : g_fwd
            assign tx_win = win_fwd;
            assign rx_win = win_rev && (pix >= PIX_W'(GUARD));
        end else begin : g_rev
            assign tx_win = win_rev;
            assign rx_win = win_fwd;
        end
    endgenerate

    sc_byte_fifo #(.DEPTH(TX_DEPTH), .SPEC(1'b0)) tx_fifo_i (
        .clk(clk), .rst(rst),
        .push(tx_wr_en), .din(tx_wr_data),
        .pop(tx_pop), .dout(tx_head),
        .count(tx_count), .free(tx_free_unused), .full(tx_full),
        .commit(1'b0), .rollback(1'b0)
    );

    sc_burst_tx #(
        .MAX_BYTES(MAX_BYTES), .CNT_W(TX_CW), .PIX_W(PIX_W), .START_PIX(TX_START)
    ) tx_i (
        .clk(clk), .rst(rst), .win(tx_win), .pix(pix),
        .fifo_count(tx_count), .fifo_head(tx_head), .local_status(local_status),
        .pop(tx_pop), .en(link_tx_en), .sym(tx_sym)
    );

    assign link_tx_sym = tx_sym;

    sc_burst_rx #(
        .MAX_BYTES(MAX_BYTES), .CNT_W(RX_CW), .ERR_W(ERR_W)
    ) rx_i (
        .clk(clk), .rst(rst), .win(rx_win),
        .valid(link_rx_valid), .sym(sym_t'(link_rx_sym)), .fifo_free(rx_free),
        .wr_en(rx_push), .wr_data(rx_push_data),
        .commit(rx_commit), .rollback(rx_rollback),
        .remote_status(remote_status), .err_cnt(rx_err_cnt)
    );

    sc_byte_fifo #(.DEPTH(RX_DEPTH), .SPEC(1'b1)) rx_fifo_i (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_push_data),
        .pop(rx_rd_en), .dout(rx_rd_data),
        .count(rx_count), .free(rx_free), .full(rx_full_unused),
        .commit(rx_commit), .rollback(rx_rollback)
    );

    assign rx_empty = (rx_count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (tx_wr_en && tx_full)
            ovf_q <= 1'b1;
    end
    assign tx_overflow = ovf_q;

    // R1: the driver is only requested inside the own transmit window
    assert_tx_window_R1: assert property (@(posedge clk) disable iff (rst)
        link_tx_en |-> $past(tx_win));

    // R4: nothing is stored during the turnaround guard
    assert_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_push && win_rev) |-> (pix >= PIX_W'(GUARD)));

    // R8: a disabled link stays silent
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $past(sc_disable, 2) |-> (!link_tx_en && !rx_push));

    // R9: the overflow flag is sticky
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $past(tx_overflow) |-> tx_overflow);

endmodule

// File: tb/sc_vblank_link_tb_top.sv
module sc_vblank_link_tb_top;
    import sc_pkg::*;

    localparam int LINE  = 280;
    localparam int MAXB  = 224;
    localparam int GUARD = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sc_disable = 1'b0;
    logic       vsync = 1'b0, hsync = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic       tx_full, tx_overflow;
    logic [7:0] local_status = '0;
    logic       link_tx_en;
    logic [8:0] link_tx_sym;
    logic       link_rx_valid = 1'b0;
    logic [8:0] link_rx_sym = '0;
    logic       rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data;
    logic       rx_empty;
    logic [7:0] remote_status;
    logic [7:0] rx_err_cnt;

    always #2 clk = ~clk;

    sc_vblank_link dut_i (
        .clk(clk), .rst(rst), .sc_disable(sc_disable),
        .vsync(vsync), .hsync(hsync),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_full(tx_full), .tx_overflow(tx_overflow),
        .local_status(local_status),
        .link_tx_en(link_tx_en), .link_tx_sym(link_tx_sym),
        .link_rx_valid(link_rx_valid), .link_rx_sym(link_rx_sym),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .remote_status(remote_status), .rx_err_cnt(rx_err_cnt)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] txm [0:4095];
    int txh = 0, txt = 0;
    logic [7:0] rxm [0:1023];
    int rxn = 0;
    logic [8:0] cap [0:1023];
    int ncap = 0;
    logic [8:0] rev [0:1023];
    int nrev = 0;
    logic [7:0] exp_remote = '0;
    int exp_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] sy(input logic c, input logic [7:0] d);
        return {c, d};
    endfunction

    task automatic write_tx(input logic [7:0] b);
        if (!tx_full) begin
            txm[txt % 4096] = b;
            txt++;
        end
        tx_wr_en   = 1'b1;
        tx_wr_data = b;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    // mode 0 good, 1 wrong check byte, 2 cut before end; good bursts update the model
    task automatic build_rev(input int len, input logic [7:0] st, input int mode, input bit expect_ok);
        logic [7:0] c;
        logic [7:0] b;
        int base;
        base = rxn;
        nrev = 0;
        c = 8'(len) ^ st;
        rev[nrev++] = sy(1'b1, K_START);
        rev[nrev++] = sy(1'b0, 8'(len));
        rev[nrev++] = sy(1'b0, st);
        for (int i = 0; i < len; i++) begin
            b = 8'($urandom);
            c ^= b;
            rev[nrev++] = sy(1'b0, b);
            if (expect_ok) rxm[base + i] = b;
        end
        rev[nrev++] = sy(1'b0, (mode == 1) ? ~c : c);
        rev[nrev++] = sy(1'b1, K_END);
        if (mode == 2) nrev = 5;
        if (expect_ok) begin
            rxn = base + len;
            exp_remote = st;
        end
    endtask

    task automatic hs_pulse();
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
    endtask

    task automatic run_frame(input int off, input bit expect_tx, input string req);
        int exp_len;
        logic [7:0] st;
        logic [7:0] c;
        int bad;
        exp_len = ((txt - txh) > MAXB) ? MAXB : (txt - txh);
        st = local_status;
        ncap = 0;
        vsync = 1'b1;
        repeat (2) @(negedge clk);
        vsync = 1'b0;
        repeat (6) @(negedge clk);
        hs_pulse();
        for (int i = 0; i < LINE; i++) begin
            if (link_tx_en) cap[ncap++] = link_tx_sym;
            @(negedge clk);
        end
        hs_pulse();
        for (int i = 0; i < LINE; i++) begin
            if (link_tx_en) cap[ncap++] = link_tx_sym;
            if (i - off >= 0 && i - off < nrev) begin
                link_rx_valid = 1'b1;
                link_rx_sym   = rev[i - off];
            end else begin
                link_rx_valid = 1'b0;
            end
            @(negedge clk);
        end
        link_rx_valid = 1'b0;
        hs_pulse();
        for (int i = 0; i < 30; i++) begin
            if (link_tx_en) cap[ncap++] = link_tx_sym;
            @(negedge clk);
        end
        nrev = 0;
        if (!expect_tx) begin
            check(ncap == 0, "R8 no symbols while disabled", ncap, 0);
            return;
        end
        check(ncap == exp_len + 5, {req, " R1 burst symbol count"}, ncap, exp_len + 5);
        if (ncap != exp_len + 5) return;
        check(cap[0] == sy(1'b1, K_START), "R2 start code", cap[0], sy(1'b1, K_START));
        check(cap[1] == sy(1'b0, 8'(exp_len)), "R3 length byte", cap[1], exp_len);
        check(cap[2] == sy(1'b0, st), "R11 status byte", cap[2], st);
        c = 8'(exp_len) ^ st;
        bad = 0;
        for (int i = 0; i < exp_len; i++) begin
            if (cap[3 + i] != sy(1'b0, txm[(txh + i) % 4096])) bad++;
            c ^= txm[(txh + i) % 4096];
        end
        check(bad == 0, "R2 payload order", bad, 0);
        check(cap[3 + exp_len] == sy(1'b0, c), "R2 check byte", cap[3 + exp_len], c);
        check(cap[4 + exp_len] == sy(1'b1, K_END), "R2 end code", cap[4 + exp_len], sy(1'b1, K_END));
        txh += exp_len;
    endtask

    task automatic drain_and_check(input string req);
        int got;
        int bad;
        got = 0;
        bad = 0;
        while (!rx_empty && got < 1024) begin
            if (got >= rxn || rx_rd_data != rxm[got]) bad++;
            got++;
            rx_rd_en = 1'b1;
            @(negedge clk);
            rx_rd_en = 1'b0;
        end
        check(got == rxn, {req, " receive byte count"}, got, rxn);
        check(bad == 0, {req, " receive byte values"}, bad, 0);
        check(remote_status == exp_remote, {req, " remote status"}, remote_status, exp_remote);
        check(int'(rx_err_cnt) == exp_err, {req, " error count"}, rx_err_cnt, exp_err);
        rxn = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C1D));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(link_tx_en == 1'b0, "R10 link_tx_en", link_tx_en, 0);
        check(tx_full == 1'b0, "R10 tx_full", tx_full, 0);
        check(tx_overflow == 1'b0, "R10 tx_overflow", tx_overflow, 0);
        check(rx_empty == 1'b1, "R10 rx_empty", rx_empty, 1);
        check(remote_status == 8'h00, "R10 remote_status", remote_status, 0);
        check(rx_err_cnt == 8'h00, "R10 rx_err_cnt", rx_err_cnt, 0);

        // R1 R2 R5 random traffic in both directions
        for (int f = 0; f < 6; f++) begin
            int n;
            n = $urandom_range(0, 40);
            for (int k = 0; k < n; k++) write_tx(8'($urandom));
            local_status = 8'($urandom);
            build_rev($urandom_range(0, 30), 8'($urandom), 0, 1'b1);
            run_frame(20 + f, 1'b1, "R1");
            drain_and_check("R5 random");
        end

        // R11 empty transmit buffer still sends status
        local_status = 8'hA5;
        run_frame(20, 1'b1, "R11");
        drain_and_check("R11 idle");

        // R6 wrong check byte
        build_rev(7, 8'h3C, 1, 1'b0);
        exp_err++;
        run_frame(20, 1'b1, "R6");
        drain_and_check("R6 bad check");

        // R7 burst cut off by the end of the window
        build_rev(10, 8'h44, 2, 1'b0);
        exp_err++;
        run_frame(20, 1'b1, "R7");
        drain_and_check("R7 truncated");

        // R7 declared length above the budget
        build_rev(230, 8'h55, 0, 1'b0);
        exp_err++;
        run_frame(18, 1'b1, "R7");
        drain_and_check("R7 too long");

        // R4 start code at pixel 15 is ignored, no error
        build_rev(5, 8'h66, 0, 1'b0);
        run_frame(GUARD - 1, 1'b1, "R4");
        drain_and_check("R4 inside guard");

        // R4 start code at pixel 16 is accepted
        build_rev(5, 8'h77, 0, 1'b1);
        run_frame(GUARD, 1'b1, "R4");
        drain_and_check("R4 guard edge");

        // R8 disabled frame: nothing moves, queued bytes survive
        sc_disable = 1'b1;
        for (int k = 0; k < 5; k++) write_tx(8'(8'h10 + k));
        build_rev(4, 8'h88, 0, 1'b0);
        run_frame(20, 1'b0, "R8");
        drain_and_check("R8 disabled");
        sc_disable = 1'b0;
        @(negedge clk);
        run_frame(20, 1'b1, "R8 resume");
        drain_and_check("R8 resume");

        // R9 fill the buffer, refuse one more write
        for (int k = 0; k < 256; k++) write_tx(8'(k * 7 + 3));
        check(tx_full == 1'b1, "R9 full after 256 writes", tx_full, 1);
        check(tx_overflow == 1'b0, "R9 no overflow yet", tx_overflow, 0);
        write_tx(8'hEE);
        check(tx_overflow == 1'b1, "R9 overflow flag", tx_overflow, 1);
        check(txt - txh == 256, "R9 refused write", txt - txh, 256);

        // R3 budget then the remainder next frame
        local_status = 8'h5A;
        run_frame(20, 1'b1, "R3 capped");
        drain_and_check("R3 capped");
        check(txt - txh == 32, "R3 remainder queued", txt - txh, 32);
        run_frame(20, 1'b1, "R3 remainder");
        drain_and_check("R3 remainder");
        check(tx_overflow == 1'b1, "R9 flag sticky", tx_overflow, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule